// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter

This block watches a vector of interrupt request lines and, every cycle, names the one request that should be serviced next. A request becomes pending on the rising edge of its line. It stays pending until the serviced index is acknowledged or software clears it. Each line has an enable bit and an 8-bit priority field. Only the upper `PRIO_BITS` bits of that field are stored, so programmed values that differ only in the dropped low bits end up at the same level.

Among the lines that are both enabled and pending, the lowest stored priority value wins. When several lines share that value, the lowest line number wins, so the choice never depends on timing or history. The winner's index and a valid flag come out of registers.

A small controller with three states runs the service handshake:
- `ST_IDLE`: no candidate exists.
- `ST_OFFER`: a winner is presented.
- `ST_CLAIM`: the one cycle after an accepted acknowledge, while the selection is recomputed without the claimed line.

Transitions:
- `ST_IDLE`→`ST_OFFER` when a candidate appears.
- `ST_OFFER`→`ST_CLAIM` on acknowledge.
- `ST_OFFER`→`ST_IDLE` when the candidates vanish.
- `ST_CLAIM`→`ST_OFFER` or `ST_CLAIM`→`ST_IDLE` depending on what remains.

Software reaches the priorities, enables and pending bits through a flat register port: an address, a write strobe, write data and combinational read data.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `sel_valid` is low and every priority, enable and pending bit reads as zero.
- R2: The address is `{region[1:0], line}`, where `line` is the low `IDX_W` bits. The regions are:
  - 0: priority of `line`.
  - 1: enable of `line` in data bit 0.
  - 2: pending of `line` in data bit 0.
  - 3: unused; reads 0 and writes to it change nothing.
- R3: A priority write keeps only data bits [7:8-PRIO_BITS]. On read-back these bits sit in place and the lower bits are zero.
- R4: A low-to-high transition on `irq_in[i]` sets pending bit i, and the bit stays set after the line falls.
- R5: A software write to the pending region sets the bit when data bit 0 is 1 and clears it when data bit 0 is 0. A set source (line edge or write of 1) wins over a clear source (write of 0 or acknowledge) in the same cycle.
- R6: Only lines that are both enabled and pending compete. Clearing an enable hides a line but leaves its pending bit unchanged.
- R7: The candidate with the numerically lowest stored priority is selected. Programmed values that become equal after truncation are treated as equal.
- R8: Among candidates with equal stored priority, the lowest line number is selected.
- R9: `sel_valid` and `sel_idx` are registered: they reflect the pending, enable and priority state one clock edge after it changes. `sel_valid` is low when there is no candidate.
- R10: An acknowledge accepted while `sel_valid` is high clears the pending bit of `sel_idx`, drives `sel_valid` low for the next cycle, and then presents the next winner. An acknowledge while `sel_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Interrupt request lines; a rising edge makes the line pending |
| reg_addr | input | IDX_W+2 | Register address `{region, line}` |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ack | input | 1 | Acknowledge of the presented index |
| sel_valid | output | 1 | A winner is being presented |
| sel_idx | output | IDX_W | Index of the presented winner |

## Verification
Timing of each result, counted from the clock edge that captures a stimulus:
- Read data is combinational. It is checked 1 ns after the address changes, with no edge in between.
- A line edge reaches the pending bit at the first edge. It reaches `sel_valid`/`sel_idx` at the second edge.
- An enable or priority write affects the selection one edge after it is captured.
- An accepted acknowledge forces one cycle of `sel_valid` low before the next winner appears.

The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge and is compared against the outputs at every falling edge. The directed checks sample at exactly those edge counts, including a check that the enable write has not yet shown up one cycle early.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_CLAIM = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        RGN_PRIO = 2'd0,
        RGN_EN   = 2'd1,
        RGN_PEND = 2'd2,
        RGN_NONE = 2'd3
    } reg_region_e;

    localparam int FIELD_W = 8;

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    parameter int IDX_W     = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           irq_in,
    input  logic [IDX_W+1:0]               reg_addr,
    input  logic                           reg_wr,
    input  logic [FIELD_W-1:0]             reg_wdata,
    output logic [FIELD_W-1:0]             reg_rdata,
    input  logic                           clr_en,
    input  logic [IDX_W-1:0]               clr_idx,
    output logic [NUM_LINES-1:0]           en_vec,
    output logic [NUM_LINES-1:0]           pend_vec,
    output logic [NUM_LINES*PRIO_BITS-1:0] prio_flat
);

    localparam int SLOTS = 1 << IDX_W;
    localparam int DROP  = FIELD_W - PRIO_BITS;

    logic [NUM_LINES-1:0] irq_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [PRIO_BITS-1:0] prio_q [NUM_LINES];

    logic [IDX_W-1:0]     line;
    reg_region_e          region;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] pend_set;
    logic [NUM_LINES-1:0] pend_clr;

    assign line   = reg_addr[IDX_W-1:0];
    assign region = reg_region_e'(reg_addr[IDX_W+1:IDX_W]);

    // Per-line write decode and pending set/clear sources.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            hit[i]      = reg_wr && (line == IDX_W'(i));
            pend_set[i] = (irq_in[i] && !irq_q[i])
                        || (hit[i] && region == RGN_PEND && reg_wdata[0]);
            pend_clr[i] = (clr_en && clr_idx == IDX_W'(i))
                        || (hit[i] && region == RGN_PEND && !reg_wdata[0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                prio_q[i] <= '0;
            end
        end else begin
            irq_q <= irq_in;
            for (int i = 0; i < NUM_LINES; i++) begin
                // Set sources win over clear sources in the same cycle.
                if (pend_set[i]) begin
                    pend_q[i] <= 1'b1;
                end else if (pend_clr[i]) begin
                    pend_q[i] <= 1'b0;
                end
                if (hit[i] && region == RGN_EN) begin
                    en_q[i] <= reg_wdata[0];
                end
                if (hit[i] && region == RGN_PRIO) begin
                    prio_q[i] <= reg_wdata[FIELD_W-1:DROP];
                end
            end
        end
    end

    // Read-back arrays padded to a power of two so any line index is safe.
    logic [FIELD_W-1:0] prio_rd [SLOTS];
    logic [SLOTS-1:0]   en_rd;
    logic [SLOTS-1:0]   pend_rd;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_rd
            if (s < NUM_LINES) begin : g_live
                assign prio_rd[s] = FIELD_W'(prio_q[s]) << DROP;
                assign en_rd[s]   = en_q[s];
                assign pend_rd[s] = pend_q[s];
            end else begin : g_pad
                assign prio_rd[s] = '0;
                assign en_rd[s]   = 1'b0;
                assign pend_rd[s] = 1'b0;
            end
        end
        for (genvar p = 0; p < NUM_LINES; p++) begin : g_flat
            assign prio_flat[p*PRIO_BITS +: PRIO_BITS] = prio_q[p];
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RGN_PRIO: reg_rdata = prio_rd[line];
            RGN_EN:   reg_rdata = {{(FIELD_W-1){1'b0}}, en_rd[line]};
            RGN_PEND: reg_rdata = {{(FIELD_W-1){1'b0}}, pend_rd[line]};
            RGN_NONE: reg_rdata = '0;
            default:  reg_rdata = '0;
        endcase
    end

    assign en_vec   = en_q;
    assign pend_vec = pend_q;

endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_LINES-1:0]           cand,
    input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
    output logic                           win_valid,
    output logic [IDX_W-1:0]               win_idx
);

    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic                 v;
        logic [PRIO_BITS-1:0] p;
        logic [IDX_W-1:0]     idx;
    } node_t;

    node_t nd [NODES];

    generate
        // Leaves sit at LEAVES-1+i; a left child always holds lower indices.
        for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < NUM_LINES) begin : g_live
                assign nd[LEAVES-1+i] = '{v:   cand[i],
                                          p:   prio_flat[i*PRIO_BITS +: PRIO_BITS],
                                          idx: IDX_W'(i)};
            end else begin : g_pad
                assign nd[LEAVES-1+i] = '{v: 1'b0, p: '0, idx: IDX_W'(i)};
            end
        end
        // Left wins on equal priority, which yields the lowest index on ties.
        for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
            assign nd[n] = (nd[2*n+1].v && (!nd[2*n+2].v || nd[2*n+1].p <= nd[2*n+2].p))
                         ? nd[2*n+1] : nd[2*n+2];
        end
    endgenerate

    assign win_valid = nd[0].v;
    assign win_idx   = nd[0].idx;

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int AW       = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 ack,
    output logic                 sel_valid,
    output logic [IDX_W-1:0]     sel_idx
);

    logic [NUM_LINES-1:0]           en_vec;
    logic [NUM_LINES-1:0]           pend_vec;
    logic [NUM_LINES*PRIO_BITS-1:0] prio_flat;
    logic                           win_valid;
    logic [IDX_W-1:0]               win_idx;
    logic [IDX_W-1:0]               sel_idx_q;
    logic                           accept;

    arb_state_e state_q;
    arb_state_e state_d;

    prio_irq_regs #(
        .NUM_LINES (NUM_LINES),
        .PRIO_BITS (PRIO_BITS),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clr_en    (accept),
        .clr_idx   (sel_idx_q),
        .en_vec    (en_vec),
        .pend_vec  (pend_vec),
        .prio_flat (prio_flat)
    );

    prio_irq_select #(
        .NUM_LINES (NUM_LINES),
        .PRIO_BITS (PRIO_BITS),
        .IDX_W     (IDX_W)
    ) u_select (
        .cand      (en_vec & pend_vec),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign accept = (state_q == ST_OFFER) && ack;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = win_valid ? ST_OFFER : ST_IDLE;
            ST_OFFER: state_d = accept ? ST_CLAIM : (win_valid ? ST_OFFER : ST_IDLE);
            ST_CLAIM: state_d = win_valid ? ST_OFFER : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State and presented-index registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_idx_q <= '0;
        end else begin
            state_q   <= state_d;
            sel_idx_q <= win_idx;
        end
    end

    // Outputs.
    always_comb begin
        sel_valid = (state_q == ST_OFFER);
        sel_idx   = sel_idx_q;
    end

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_BITS = 3,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [IDX_W+1:0]     reg_addr,
    input logic [7:0]           reg_rdata,
    input logic                 ack,
    input logic                 sel_valid,
    input logic [IDX_W-1:0]     sel_idx,
    input logic [NUM_LINES-1:0] en_vec,
    input logic [NUM_LINES-1:0] pend_vec
);

    localparam logic [7:0] LOW_MASK = 8'hFF >> PRIO_BITS;

    logic [NUM_LINES-1:0] cand_q;
    logic [NUM_LINES-1:0] irq_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q   <= '0;
            irq_prev <= '0;
        end else begin
            cand_q   <= en_vec & pend_vec;
            irq_prev <= irq_in;
        end
    end

    assert_sel_is_candidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> cand_q[sel_idx]);

    assert_idle_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(en_vec & pend_vec)) |=> !sel_valid);

    assert_claim_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && ack) |=> !sel_valid);

    assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[IDX_W+1:IDX_W] == 2'd0) |-> ((reg_rdata & LOW_MASK) == 8'd0));

    assert_unused_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[IDX_W+1:IDX_W] == 2'd3) |-> (reg_rdata == 8'd0));

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
            assert_rise_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_in[i] && !irq_prev[i]) |=> pend_vec[i]);
        end
    endgenerate

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ack       (ack),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec)
);

// File: tb/prio_irq_arbiter_bench.sv
`timescale 1ns/1ps
module prio_irq_arbiter_bench;

    localparam int N     = 32;
    localparam int PB    = 3;
    localparam int IW    = 5;
    localparam logic [7:0] KEEP = 8'hFF << (8 - PB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [IW+1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          ack = 1'b0;
    logic          sel_valid;
    logic [IW-1:0] sel_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_arbiter #(.NUM_LINES(N), .PRIO_BITS(PB)) u_prio_irq_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack       (ack),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx)
    );

    // Behavioural reference model, advanced on every rising edge.
    logic [7:0] m_prio [N];
    bit         m_en   [N];
    bit         m_pend [N];
    bit         m_irq  [N];
    bit         m_valid;
    int         m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 8'd0; m_en[i] = 0; m_pend[i] = 0; m_irq[i] = 0;
            end
            m_valid = 0;
            m_idx   = 0;
        end else begin
            bit   best_v;
            int   best_i;
            bit   took;
            int   wline;
            int   wrgn;
            best_v = 0;
            best_i = 0;
            for (int i = 0; i < N; i++) begin
                if (m_en[i] && m_pend[i] && (!best_v || m_prio[i] < m_prio[best_i])) begin
                    best_v = 1;
                    best_i = i;
                end
            end
            took  = m_valid && ack;
            wline = int'(reg_addr[IW-1:0]);
            wrgn  = int'(reg_addr[IW+1:IW]);
            for (int i = 0; i < N; i++) begin
                bit s;
                bit c;
                s = irq_in[i] && !m_irq[i];
                c = took && (i == m_idx);
                if (reg_wr && wline == i && wrgn == 2) begin
                    if (reg_wdata[0]) s = 1; else c = 1;
                end
                if (s) m_pend[i] = 1; else if (c) m_pend[i] = 0;
                m_irq[i] = irq_in[i];
                if (reg_wr && wline == i && wrgn == 1) m_en[i] = reg_wdata[0];
                if (reg_wr && wline == i && wrgn == 0) m_prio[i] = reg_wdata & KEEP;
            end
            m_valid = took ? 0 : best_v;
            m_idx   = best_i;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sel_valid === m_valid, "R9 model valid", int'(sel_valid), int'(m_valid));
            if (m_valid)
                check(int'(sel_idx) == m_idx, "R7 R8 model winner", int'(sel_idx), m_idx);
        end
    end

    task automatic wr(input int rgn, input int line, input logic [7:0] d);
        reg_addr  = {rgn[1:0], line[IW-1:0]};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int rgn, input int line, input int exp, input string tag);
        reg_addr = {rgn[1:0], line[IW-1:0]};
        #1;
        check(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    endtask

    task automatic expect_sel(input bit v, input int idx, input string tag);
        check(sel_valid === v, tag, int'(sel_valid), int'(v));
        if (v) check(int'(sel_idx) == idx, tag, int'(sel_idx), idx);
    endtask

    task automatic pulse(input int line);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in[line] = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_sel(0, 0, "R1 valid after reset");
        rd(0, 0, 0, "R1 priority reset");
        rd(1, 7, 0, "R1 enable reset");
        rd(2, 31, 0, "R1 pending reset");

        // R3 truncation of stored priority
        wr(0, 5, 8'h5F);
        rd(0, 5, 8'h40, "R3 priority read-back truncated");
        wr(0, 9, 8'h20);
        wr(0, 3, 8'h3F);
        rd(0, 3, 8'h20, "R3 collapsed value read-back");
        wr(1, 5, 8'h01);
        wr(1, 9, 8'h01);
        wr(1, 3, 8'h01);
        rd(1, 9, 1, "R2 enable read-back");

        // R4 / R7: edge sets pending, lower value wins
        irq_in[5] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        irq_in[5] = 1'b0; irq_in[9] = 1'b0;
        @(negedge clk);
        expect_sel(1, 9, "R7 lower priority value wins");
        rd(2, 5, 1, "R4 pending held after line falls");

        // R8: 0x3F and 0x20 collapse to one level; lower index wins
        pulse(3);
        @(negedge clk);
        expect_sel(1, 3, "R8 tie after truncation goes to lower index");

        // R6: disabling hides the line but keeps it pending
        wr(1, 3, 8'h00);
        @(negedge clk);
        expect_sel(1, 9, "R6 disabled line not selected");
        rd(2, 3, 1, "R6 pending kept while disabled");

        // R10: acknowledge handshake
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        expect_sel(0, 0, "R10 gap cycle after acknowledge");
        rd(2, 9, 0, "R10 acknowledged pending cleared");
        @(negedge clk);
        expect_sel(1, 5, "R10 next winner after gap");
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        expect_sel(0, 0, "R9 no candidate leaves valid low");
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rd(2, 3, 1, "R10 acknowledge while idle ignored");

        // R5: software pending writes, set beats clear
        wr(2, 12, 8'h01);
        rd(2, 12, 1, "R5 software set");
        wr(2, 12, 8'h00);
        rd(2, 12, 0, "R5 software clear");
        irq_in[12] = 1'b1;
        wr(2, 12, 8'h00);
        irq_in[12] = 1'b0;
        rd(2, 12, 1, "R5 edge wins over clear write");

        // R2: unused region
        wr(3, 12, 8'hFF);
        rd(3, 12, 0, "R2 unused region reads zero");
        rd(0, 12, 0, "R2 unused region write ignored");

        // R9: enable takes effect one edge later; line 12 priority 0 wins
        reg_addr = {2'd1, 5'd12}; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_sel(0, 0, "R9 not visible before register stage");
        @(negedge clk);
        expect_sel(1, 12, "R9 visible one edge later");

        // Randomised phase compared by the model every cycle.
        for (int c = 0; c < 4000; c++) begin
            irq_in   = irq_in ^ N'($urandom & $urandom & $urandom);
            ack      = ($urandom % 3) == 0;
            reg_wr   = ($urandom % 4) == 0;
            reg_addr = (IW+2)'($urandom);
            reg_wdata = 8'($urandom);
            @(negedge clk);
        end
        reg_wr = 1'b0;
        ack = 1'b0;
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule